// File: doc/BRIEF.md
# Serial Clock-Chip Transaction Engine

This block is a host-side master for a slow three-wire serial link to a real-time-clock slave. Without it, software toggles each wire through register writes. The host hands the engine one request at a time. A request carries a direction flag, a 3-bit slave register address and a 32-bit write word. The engine then runs the whole exchange in hardware and answers with a single completion pulse. The pulse carries the read word and an error flag.

Before any serial traffic starts, the engine parks the select, clock and data lines low and waits for the slave to report that it is ready. If the slave stays silent for the timeout window, the engine pulses a reset to the slave and waits again. After the last attempt it gives up and reports an error. Once the slave is ready, the engine clocks out the address and then a direction bit. After that it either sends 32 data bits or collects 32 bits from the slave's return line. All clock phase lengths are parameters counted in system clock cycles. The nominal settings are 5 us per half period and 300 ms per wait window.

Top module: `srtc_bus_master`

## Requirements
- R1: After reset, reqReady is 1, and serEn, serClk, serDin, slaveRst and doneValid are all 0.
- R2: The engine takes one request at a time. reqReady is 0 from the accepting edge until the completion pulse. A reqValid seen while reqReady is 0 is ignored: it causes no completion and no serial traffic.
- R3: When a request is accepted, serEn, serClk and serDin are driven low. No serial clock edge occurs until slaveReady has been seen high.
- R4: If slaveReady stays low for TIMEOUT_CYC cycles of one wait, slaveRst goes high for exactly 8 cycles and a new wait starts. There are at most ATTEMPTS waits per request and ATTEMPTS-1 reset pulses. When every wait times out, completion comes (3*TIMEOUT_CYC + 2*8 + 1) cycles after the request is presented, for ATTEMPTS = 3.
- R5: When every attempt has timed out, the completion has doneErr = 1 and doneRdata = 0, and serEn and serClk never go high for that request.
- R6: The 3 address bits go out MSB first. serEn is 1 at each of their three serClk rising edges and falls after the third rising edge.
- R7: serDin is 0 just after serEn falls. The fourth rising edge carries the direction bit with serEn = 0: 1 for a write, 0 for a read. During a read, serDin stays 0 through the data bits.
- R8: Each bit period works as follows. serDin is set, HALF_CYC cycles pass, serClk goes low, then serClk stays low for exactly HALF_CYC cycles and rises.
- R9: On a write, the 32 data bits follow the direction bit, MSB first, one per serClk rising edge. Each transaction has exactly 36 rising edges. The completion has doneErr = 0 and doneRdata = 0.
- R10: On a read, bit 31 down to bit 0 of doneRdata are taken from serDout one cycle after each of the 32 data rising edges.
- R11: doneValid is a single-cycle pulse. After a successful transfer, serEn = 0, serClk = 1 and serDin = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is 1 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Slave register address |
| reqWdata | input | DATA_W | Word to write |
| reqReady | output | 1 | Engine idle and able to accept |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Completion ended in a ready timeout |
| doneRdata | output | DATA_W | Read word, zero for writes and errors |
| slaveReady | input | 1 | Ready flag from the slave |
| slaveRst | output | 1 | Reset pulse to the slave |
| serEn | output | 1 | Serial select line |
| serClk | output | 1 | Serial clock line |
| serDin | output | 1 | Serial data toward the slave |
| serDout | input | 1 | Serial data from the slave |

## Verification
A bit counter that loses its place would show up at once as a transaction whose number of serClk rising edges is not 36. It could also show as the direction bit landing under serEn high. Either would be seen before the completion pulse. If the shift register or data-in select is corrupted, the captured address or data word comes out wrong. On a read the corruption surfaces in doneRdata in the completion cycle. If the wait timer or the attempt counter has drifted, the reset pulse count and width change, and so does the completion time of an exhausted request. These are measured to the cycle, so an error of a single cycle is seen.

// File: rtl/srtc_pkg.sv
package srtc_pkg;

  // Width of the slave reset pulse, in system clock cycles.
  localparam int RST_PULSE_CYC = 8;

  typedef enum logic [1:0] {DIN_ZERO, DIN_MSB, DIN_NEXT, DIN_DIR} dinSel_e;
  typedef enum logic [1:0] {CNT_ADDR, CNT_DIR, CNT_DATA} cntSel_e;
  typedef enum logic [1:0] {SEG_ADDR, SEG_DIR, SEG_DATA} seg_e;
  typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_RSTP, ST_BITA, ST_BITB, ST_BITC, ST_GAP} state_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    loadReq;
    logic    linesIdle;
    logic    timerClr;
    logic    attemptClr;
    logic    attemptInc;
    logic    rstOn;
    logic    rstOff;
    logic    enSet;
    logic    enClr;
    logic    clkLow;
    logic    clkHigh;
    logic    dinLoad;
    dinSel_e dinSel;
    logic    loadWdata;
    logic    shiftOut;
    logic    sampleIn;
    logic    cntLoad;
    cntSel_e cntSel;
    logic    cntDec;
    logic    done;
    logic    err;
  } ctlStrobe_t;

  // Status flags from datapath to control.
  typedef struct packed {
    logic waitExpired;
    logic halfDone;
    logic rstDone;
    logic attemptLast;
    logic bitLast;
    logic isWrite;
  } dpFlag_t;

endpackage

// File: rtl/srtc_ctrl.sv
module srtc_ctrl
  import srtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       slaveReady,
  input  dpFlag_t    flg,
  output ctlStrobe_t ctl,
  output logic       reqReady
);

  state_e st, stNext;
  seg_e   seg, segNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      seg <= SEG_ADDR;
    end else begin
      st  <= stNext;
      seg <= segNext;
    end
  end

  assign reqReady = (st == ST_IDLE);

  always_comb begin
    ctl     = '0;
    stNext  = st;
    segNext = seg;
    case (st)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadReq    = 1'b1;
          ctl.linesIdle  = 1'b1;
          ctl.timerClr   = 1'b1;
          ctl.attemptClr = 1'b1;
          stNext         = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (slaveReady) begin
          ctl.enSet    = 1'b1;
          ctl.dinLoad  = 1'b1;
          ctl.dinSel   = DIN_MSB;
          ctl.cntLoad  = 1'b1;
          ctl.cntSel   = CNT_ADDR;
          ctl.timerClr = 1'b1;
          segNext      = SEG_ADDR;
          stNext       = ST_BITA;
        end else if (flg.waitExpired) begin
          if (flg.attemptLast) begin
            ctl.done = 1'b1;
            ctl.err  = 1'b1;
            stNext   = ST_IDLE;
          end else begin
            ctl.rstOn    = 1'b1;
            ctl.timerClr = 1'b1;
            stNext       = ST_RSTP;
          end
        end
      end
      ST_RSTP: begin
        if (flg.rstDone) begin
          ctl.rstOff     = 1'b1;
          ctl.timerClr   = 1'b1;
          ctl.attemptInc = 1'b1;
          stNext         = ST_WAIT;
        end
      end
      ST_BITA: begin
        if (flg.halfDone) begin
          ctl.clkLow   = 1'b1;
          ctl.timerClr = 1'b1;
          stNext       = ST_BITB;
        end
      end
      ST_BITB: begin
        if (flg.halfDone) begin
          ctl.clkHigh = 1'b1;
          stNext      = ST_BITC;
        end
      end
      ST_BITC: begin
        ctl.cntDec = 1'b1;
        if (seg == SEG_DATA && !flg.isWrite) ctl.sampleIn = 1'b1;
        else if (seg != SEG_DIR)             ctl.shiftOut = 1'b1;
        if (flg.bitLast) begin
          ctl.dinLoad = 1'b1;
          ctl.dinSel  = DIN_ZERO;
          case (seg)
            SEG_ADDR: begin
              ctl.enClr   = 1'b1;
              ctl.cntLoad = 1'b1;
              ctl.cntSel  = CNT_DIR;
              segNext     = SEG_DIR;
              stNext      = ST_GAP;
            end
            SEG_DIR: begin
              ctl.cntLoad   = 1'b1;
              ctl.cntSel    = CNT_DATA;
              ctl.loadWdata = flg.isWrite;
              segNext       = SEG_DATA;
              stNext        = ST_GAP;
            end
            default: begin
              ctl.done = 1'b1;
              stNext   = ST_IDLE;
            end
          endcase
        end else begin
          if (seg != SEG_DATA || flg.isWrite) begin
            ctl.dinLoad = 1'b1;
            ctl.dinSel  = DIN_NEXT;
          end
          ctl.timerClr = 1'b1;
          stNext       = ST_BITA;
        end
      end
      ST_GAP: begin
        ctl.timerClr = 1'b1;
        stNext       = ST_BITA;
        if (seg == SEG_DIR) begin
          ctl.dinLoad = 1'b1;
          ctl.dinSel  = DIN_DIR;
        end else if (flg.isWrite) begin
          ctl.dinLoad = 1'b1;
          ctl.dinSel  = DIN_MSB;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/srtc_dp.sv
module srtc_dp
  import srtc_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int HALF_CYC    = 250,
  parameter int TIMEOUT_CYC = 15_000_000,
  parameter int ATTEMPTS    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              serDout,
  input  ctlStrobe_t        ctl,
  output dpFlag_t           flg,
  output logic              serEn,
  output logic              serClk,
  output logic              serDin,
  output logic              slaveRst,
  output logic              doneValid,
  output logic              doneErr,
  output logic [DATA_W-1:0] doneRdata
);

  localparam int MAX_A = (TIMEOUT_CYC > HALF_CYC) ? TIMEOUT_CYC : HALF_CYC;
  localparam int MAX_C = (MAX_A > RST_PULSE_CYC) ? MAX_A : RST_PULSE_CYC;
  localparam int TW    = $clog2(MAX_C + 1);
  localparam int CW    = $clog2(DATA_W + 1);
  localparam int AW    = $clog2(ATTEMPTS + 1);
  localparam logic [TW-1:0] WAIT_LAST = TW'(TIMEOUT_CYC - 1);
  localparam logic [TW-1:0] HALF_LAST = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] RST_LAST  = TW'(RST_PULSE_CYC - 1);

  logic [TW-1:0]     timer;
  logic [AW-1:0]     attempt;
  logic [CW-1:0]     bitCnt;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] wdataQ;
  logic              wrQ;

  always_ff @(posedge clk) begin
    if (!rstN) timer <= '0;
    else if (ctl.timerClr) timer <= '0;
    else timer <= timer + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.attemptClr) attempt <= '0;
    else if (ctl.attemptInc) attempt <= attempt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrQ    <= 1'b0;
      wdataQ <= '0;
    end else if (ctl.loadReq) begin
      wrQ    <= reqWrite;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              shiftReg <= '0;
    else if (ctl.loadReq)   shiftReg <= {reqAddr, {(DATA_W-ADDR_W){1'b0}}};
    else if (ctl.loadWdata) shiftReg <= wdataQ;
    else if (ctl.sampleIn)  shiftReg <= {shiftReg[DATA_W-2:0], serDout};
    else if (ctl.shiftOut)  shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) bitCnt <= '0;
    else if (ctl.cntLoad) begin
      case (ctl.cntSel)
        CNT_ADDR: bitCnt <= CW'(ADDR_W);
        CNT_DIR:  bitCnt <= CW'(1);
        default:  bitCnt <= CW'(DATA_W);
      endcase
    end else if (ctl.cntDec) bitCnt <= bitCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.linesIdle) begin
      serEn  <= 1'b0;
      serClk <= 1'b0;
      serDin <= 1'b0;
    end else begin
      if (ctl.enSet)      serEn <= 1'b1;
      else if (ctl.enClr) serEn <= 1'b0;
      if (ctl.clkLow)       serClk <= 1'b0;
      else if (ctl.clkHigh) serClk <= 1'b1;
      if (ctl.dinLoad) begin
        case (ctl.dinSel)
          DIN_MSB:  serDin <= shiftReg[DATA_W-1];
          DIN_NEXT: serDin <= shiftReg[DATA_W-2];
          DIN_DIR:  serDin <= wrQ;
          default:  serDin <= 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           slaveRst <= 1'b0;
    else if (ctl.rstOn)  slaveRst <= 1'b1;
    else if (ctl.rstOff) slaveRst <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneErr   <= 1'b0;
    end else begin
      doneValid <= ctl.done;
      if (ctl.done) doneErr <= ctl.err;
    end
  end

  assign doneRdata = (doneValid && !doneErr && !wrQ) ? shiftReg : '0;

  assign flg.waitExpired = (timer == WAIT_LAST);
  assign flg.halfDone    = (timer == HALF_LAST);
  assign flg.rstDone     = (timer == RST_LAST);
  assign flg.attemptLast = (attempt == AW'(ATTEMPTS - 1));
  assign flg.bitLast     = (bitCnt == CW'(1));
  assign flg.isWrite     = wrQ;

endmodule

// File: rtl/srtc_bus_master.sv
module srtc_bus_master
  import srtc_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int HALF_CYC    = 250,
  parameter int TIMEOUT_CYC = 15_000_000,
  parameter int ATTEMPTS    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              doneValid,
  output logic              doneErr,
  output logic [DATA_W-1:0] doneRdata,
  input  logic              slaveReady,
  output logic              slaveRst,
  output logic              serEn,
  output logic              serClk,
  output logic              serDin,
  input  logic              serDout
);

  ctlStrobe_t ctl;
  dpFlag_t    flg;

  srtc_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .slaveReady (slaveReady),
    .flg        (flg),
    .ctl        (ctl),
    .reqReady   (reqReady)
  );

  srtc_dp #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .HALF_CYC    (HALF_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .ATTEMPTS    (ATTEMPTS)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .serDout   (serDout),
    .ctl       (ctl),
    .flg       (flg),
    .serEn     (serEn),
    .serClk    (serClk),
    .serDin    (serDin),
    .slaveRst  (slaveRst),
    .doneValid (doneValid),
    .doneErr   (doneErr),
    .doneRdata (doneRdata)
  );

endmodule

// File: rtl/srtc_bus_master_chk.sv
module srtc_bus_master_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              doneValid,
  input logic              doneErr,
  input logic [DATA_W-1:0] doneRdata,
  input logic              slaveRst,
  input logic              serEn,
  input logic              serClk,
  input logic              serDin
);

  // R11: completion is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R4: the slave reset is only pulsed while the lines are parked low
  a_r4_rst_lines_quiet: assert property (@(posedge clk) disable iff (!rstN)
    slaveRst |-> (!serEn && !serClk && !serDin));

  // R5: a timed-out completion leaves select and clock low, with no read word
  a_r5_err_no_traffic: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneErr) |-> (!serEn && !serClk && doneRdata == '0));

  // R2: serial traffic only starts while the engine is busy
  a_r2_select_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serEn) |-> !reqReady);

  // R3: a falling clock only happens while a request is held
  a_r3_clk_fall_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serClk) |-> !reqReady);

  // R8: data-in is settled before the clock falls
  a_r8_din_stable_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serClk) |-> $stable(serDin));

  // R6: select drops only after an address bit has been clocked (clock high)
  a_r6_en_drop_clk_high: assert property (@(posedge clk) disable iff (!rstN)
    $fell(serEn) |-> serClk);

endmodule

bind srtc_bus_master srtc_bus_master_chk #(.DATA_W(DATA_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .doneValid (doneValid),
  .doneErr   (doneErr),
  .doneRdata (doneRdata),
  .slaveRst  (slaveRst),
  .serEn     (serEn),
  .serClk    (serClk),
  .serDin    (serDin)
);

// File: tb/test_srtc_bus_master.sv
`timescale 1ns/1ps
module test_srtc_bus_master;

  localparam int HALF  = 3;
  localparam int TOUT  = 40;
  localparam int ATT   = 3;
  localparam int RST_W = 8;
  localparam int NVEC  = 6;

  // {write, addr[2:0], wdata[31:0], slave read word[31:0]}
  localparam logic [67:0] VECS [0:NVEC-1] = '{
    {1'b1, 3'd5, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 3'd0, 32'h0,         32'h8000_0001},
    {1'b1, 3'd7, 32'h0000_0001, 32'h0},
    {1'b0, 3'd2, 32'h0,         32'h1234_5678},
    {1'b0, 3'd7, 32'h0,         32'hFFFF_FFFF},
    {1'b1, 3'd0, 32'h8000_0000, 32'h0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [2:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic reqReady, doneValid, doneErr;
  logic [31:0] doneRdata;
  logic slaveReady = 1'b0;
  logic slaveRst, serEn, serClk, serDin;
  logic serDout = 1'b0;

  always #10 clk = ~clk;

  srtc_bus_master #(
    .HALF_CYC(HALF), .TIMEOUT_CYC(TOUT), .ATTEMPTS(ATT)
  ) i_srtc_bus_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .doneValid(doneValid), .doneErr(doneErr), .doneRdata(doneRdata),
    .slaveReady(slaveReady), .slaveRst(slaveRst), .serEn(serEn),
    .serClk(serClk), .serDin(serDin), .serDout(serDout)
  );

  int checks = 0;
  int fails = 0;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Slave model and line monitors
  logic [31:0] slaveVal = '0;
  logic capDin [0:63];
  logic capEn  [0:63];
  int riseCnt = 0;
  int clkRiseTotal = 0;
  int enRiseTotal = 0;
  int rstPulses = 0;
  int rstBad = 0;
  int widthBad = 0;
  int widthSeen = 0;
  int doneCnt = 0;
  time tFall = 0;
  time tRst = 0;

  always @(posedge serEn) begin
    riseCnt = 0;
    enRiseTotal++;
  end

  always @(negedge serClk) tFall = $time;

  always @(posedge serClk) begin
    clkRiseTotal++;
    if (riseCnt > 0) begin
      widthSeen++;
      if ($time - tFall != HALF * 20) widthBad++;
    end
    if (riseCnt < 64) begin
      capDin[riseCnt] = serDin;
      capEn[riseCnt]  = serEn;
    end
    if (riseCnt >= 4 && riseCnt < 36) serDout = slaveVal[35 - riseCnt];
    riseCnt++;
  end

  always @(negedge serEn) begin
    #1;
    check(serDin == 1'b0, "R7 din low after select drop", 64'(serDin), 64'd0);
  end

  always @(posedge slaveRst) tRst = $time;
  always @(negedge slaveRst) begin
    rstPulses++;
    if ($time - tRst != RST_W * 20) rstBad++;
  end

  always @(posedge clk) if (doneValid) doneCnt++;

  function automatic logic [2:0] capAddr();
    return {capDin[0], capDin[1], capDin[2]};
  endfunction

  function automatic logic [31:0] capData();
    logic [31:0] w;
    for (int k = 0; k < 32; k++) w[31-k] = capDin[4+k];
    return w;
  endfunction

  task automatic runReq(input logic wr, input logic [2:0] a, input logic [31:0] wd,
                        output logic err, output logic [31:0] rd, output int dur);
    time t0;
    @(negedge clk);
    t0 = $time;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (doneValid !== 1'b1) @(negedge clk);
    err = doneErr;
    rd  = doneRdata;
    dur = int'($time - t0);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic err;
    logic [31:0] rd;
    int dur;
    int p0, c0, e0, d0;

    // R1: reset state
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reqReady", 64'(reqReady), 64'd1);
    check({serEn, serClk, serDin, slaveRst, doneValid} == 5'b0, "R1 outputs low",
          64'({serEn, serClk, serDin, slaveRst, doneValid}), 64'd0);

    // Vector table, slave always ready
    slaveReady = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      logic        vw;
      logic [2:0]  va;
      logic [31:0] vd, vr;
      {vw, va, vd, vr} = VECS[v];
      slaveVal = vr;
      runReq(vw, va, vd, err, rd, dur);
      check(capAddr() == va, "R6 address bits", 64'(capAddr()), 64'(va));
      check(capEn[0] && capEn[1] && capEn[2], "R6 select high on address",
            64'({capEn[0], capEn[1], capEn[2]}), 64'h7);
      check(!capEn[3] && capDin[3] == vw, "R7 direction bit",
            64'({capEn[3], capDin[3]}), 64'({1'b0, vw}));
      check(riseCnt == 36, "R9 rising edge count", 64'(riseCnt), 64'd36);
      check(err == 1'b0, "R9 no error", 64'(err), 64'd0);
      if (vw) begin
        check(capData() == vd, "R9 write data", 64'(capData()), 64'(vd));
        check(rd == 32'd0, "R9 write rdata zero", 64'(rd), 64'd0);
      end else begin
        check(rd == vr, "R10 read data", 64'(rd), 64'(vr));
        check(capData() == 32'd0, "R7 din low in read data", 64'(capData()), 64'd0);
      end
      @(negedge clk);
      check(doneValid == 1'b0, "R11 done single pulse", 64'(doneValid), 64'd0);
      check({serEn, serClk, serDin} == 3'b010, "R11 end line state",
            64'({serEn, serClk, serDin}), 64'h2);
      check(reqReady == 1'b1, "R2 ready after done", 64'(reqReady), 64'd1);
    end

    // R3: no clocking while the slave is not ready
    slaveReady = 1'b0;
    slaveVal = 32'h0F0F_00FF;
    c0 = clkRiseTotal; p0 = rstPulses;
    fork
      runReq(1'b0, 3'd4, 32'h0, err, rd, dur);
      begin
        repeat (25) @(negedge clk);
        check(serEn == 1'b0 && clkRiseTotal == c0, "R3 lines parked while waiting",
              64'(clkRiseTotal - c0), 64'd0);
        check(serClk == 1'b0 && serDin == 1'b0, "R3 clock and din low",
              64'({serClk, serDin}), 64'd0);
        slaveReady = 1'b1;
      end
    join
    check(rd == 32'h0F0F_00FF && err == 1'b0, "R3 read after late ready", 64'(rd), 64'h0F0F_00FF);
    check(rstPulses == p0, "R3 no reset within window", 64'(rstPulses - p0), 64'd0);

    // R4: one timeout, one reset pulse, then success
    slaveReady = 1'b0;
    slaveVal = 32'hCAFE_0042;
    p0 = rstPulses;
    fork
      runReq(1'b0, 3'd1, 32'h0, err, rd, dur);
      begin
        @(negedge slaveRst);
        @(negedge clk);
        slaveReady = 1'b1;
      end
    join
    check(rstPulses - p0 == 1, "R4 single retry pulse", 64'(rstPulses - p0), 64'd1);
    check(err == 1'b0 && rd == 32'hCAFE_0042, "R4 retry succeeds", 64'(rd), 64'hCAFE_0042);

    // R4/R5: all attempts time out
    slaveReady = 1'b0;
    p0 = rstPulses; c0 = clkRiseTotal; e0 = enRiseTotal;
    runReq(1'b1, 3'd6, 32'h5555_AAAA, err, rd, dur);
    check(err == 1'b1, "R5 timeout error", 64'(err), 64'd1);
    check(rd == 32'd0, "R5 error rdata zero", 64'(rd), 64'd0);
    check(clkRiseTotal == c0 && enRiseTotal == e0, "R5 no serial traffic",
          64'(clkRiseTotal - c0), 64'd0);
    check(rstPulses - p0 == ATT - 1, "R4 reset pulse count", 64'(rstPulses - p0), 64'(ATT - 1));
    check(dur == (3 * TOUT + 2 * RST_W + 1) * 20, "R4 exhaustion time", 64'(dur),
          64'((3 * TOUT + 2 * RST_W + 1) * 20));
    check(rstBad == 0, "R4 reset pulse width", 64'(rstBad), 64'd0);
    @(negedge clk);
    check(doneValid == 1'b0, "R11 error done single pulse", 64'(doneValid), 64'd0);

    // R2: request during a transfer is ignored
    slaveReady = 1'b1;
    d0 = doneCnt; e0 = enRiseTotal;
    fork
      runReq(1'b1, 3'd3, 32'h0123_4567, err, rd, dur);
      begin
        @(posedge serEn);
        @(negedge clk);
        check(reqReady == 1'b0, "R2 busy during transfer", 64'(reqReady), 64'd0);
        reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 3'd6;
        @(negedge clk);
        reqValid = 1'b0;
      end
    join
    check(capAddr() == 3'd3 && capDin[3] == 1'b1, "R2 original request kept",
          64'({capAddr(), capDin[3]}), 64'({3'd3, 1'b1}));
    check(capData() == 32'h0123_4567, "R2 original data kept", 64'(capData()), 64'h0123_4567);
    repeat (100) @(negedge clk);
    check(doneCnt - d0 == 1 && enRiseTotal - e0 == 1, "R2 ignored request left no trace",
          64'(doneCnt - d0), 64'd1);

    check(widthBad == 0 && widthSeen > 0, "R8 clock low width", 64'(widthBad), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule